// File: doc/BRIEF.md
# Two-Phase Fetch-Execute Sequencer

This block is a small control core that runs straight-line programs with conditional branches. It holds a program counter, an instruction register and a small register file. It shares a single word-wide memory port between instruction fetches and data accesses. Every instruction first spends one cycle in a fetch phase, which captures the word at the program counter into the instruction register. It then spends one cycle in an execute phase, which decodes that word and acts on it. Load and Store need one further memory cycle before the core returns to fetch.

Instructions are 32 bits wide. The opcode is in bits 31:28. The destination register is in bits 27:24, the first source register in 23:20, the second source register in 19:16, and a 16-bit immediate in 15:0. The immediate serves as an absolute byte address, as a branch target or as a constant. Memory is byte-addressed with 4-byte words, so the program counter steps by 4. The memory read path is combinational: `mem_rdata` must show the word at `mem_addr` within the same cycle.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the core is in fetch with `mem_addr` and `pc_o` equal to the parameter START_PC. `done` is 0 and `mem_we` is 0. All registers reset to 0.
- R2: An instruction that is not a taken branch and not halt moves the PC to the old PC plus 4, so successive fetch addresses step by 4.
- R3: Each instruction takes two cycles from one fetch to the next. Load (opcode 1) and Store (opcode 2) take three, because of one extra memory cycle.
- R4: Load (opcode 1) copies the word at byte address imm into register rd. It never asserts `mem_we`, so memory is left unchanged.
- R5: Store (opcode 2) writes register ra to byte address imm with a single-cycle `mem_we` pulse in its memory cycle.
- R6: Add (opcode 3) writes ra+rb to rd. When rd equals a source, the old source value is used.
- R7: Subtract-immediate (opcode 4) writes ra minus the sign-extended imm to rd.
- R8: Branch-if-positive (opcode 5) loads imm into the PC only when ra, read as signed, is strictly greater than zero. A zero or negative value falls through to PC+4.
- R9: Branch-if-greater (opcode 6) loads imm into the PC only when ra is greater than rb as signed values. Equal or smaller values fall through. Neither register is modified.
- R10: Halt (opcode 7) stops sequencing. `done` rises and stays high, `pc_o` holds the halt address, and no further fetch or write occurs.
- R11: Any other opcode acts as a no-op that advances the PC by 4 in two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Byte address: PC in fetch, imm in the memory cycle |
| mem_rdata | input | 32 | Word at mem_addr, combinational |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for Store |
| fetch_o | output | 1 | High in the fetch phase |
| pc_o | output | AW | Program counter |
| done | output | 1 | High once halt has executed |

## Verification
Two functions fall in the same cycle in an Add whose destination is also a source. In that execute cycle the register file is read for the operand and written with the result on the same edge. The program provokes this with an Add that accumulates into one of its own sources, then stores that register. The scoreboard judges the stored word against the sum of the old values. A second such case is a branch in the cycle after a Subtract-immediate: the loop's count-down result must be seen immediately by the positive-branch test. This is judged by the exact sequence of fetch addresses and cycle gaps.

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq #(
  parameter int AW       = 16,
  parameter int NREGS    = 8,
  parameter int START_PC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   mem_wdata,
  output logic          mem_we,
  output logic          fetch_o,
  output logic [AW-1:0] pc_o,
  output logic          done
);
  localparam int RIW = $clog2(NREGS);
  localparam logic [3:0] OP_LD = 4'd1, OP_ST = 4'd2, OP_ADD = 4'd3, OP_SUBI = 4'd4,
                         OP_BPOS = 4'd5, OP_BGT = 4'd6, OP_HALT = 4'd7;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM, S_HALT} state_t;
  state_t state;

  logic [AW-1:0] pc;
  logic [31:0]   ir;
  logic [31:0]   rf [NREGS];

  wire [3:0]     op   = ir[31:28];
  wire [RIW-1:0] rd   = ir[24 +: RIW];
  wire [RIW-1:0] ra   = ir[20 +: RIW];
  wire [RIW-1:0] rb   = ir[16 +: RIW];
  wire [31:0]    va   = rf[ra];
  wire [31:0]    vb   = rf[rb];
  wire [31:0]    simm = {{16{ir[15]}}, ir[15:0]};
  wire [AW-1:0]  iadr = AW'(ir[15:0]);
  wire [AW-1:0]  pseq = pc + AW'(4);

  assign mem_addr  = (state == S_MEM) ? iadr : pc;
  assign mem_wdata = va;
  assign mem_we    = (state == S_MEM) && (op == OP_ST);
  assign fetch_o   = (state == S_FETCH);
  assign done      = (state == S_HALT);
  assign pc_o      = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= AW'(START_PC);
      ir    <= '0;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          pc    <= pseq;
          case (op)
            OP_LD, OP_ST: state <= S_MEM;
            OP_ADD:  rf[rd] <= va + vb;
            OP_SUBI: rf[rd] <= va - simm;
            OP_BPOS: if ($signed(va) > 0) pc <= iadr;
            OP_BGT:  if ($signed(va) > $signed(vb)) pc <= iadr;
            OP_HALT: begin
              pc    <= pc;
              state <= S_HALT;
            end
            default: ;
          endcase
        end
        S_MEM: begin
          if (op == OP_LD) rf[rd] <= mem_rdata;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  p_exec_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |=> state == S_EXEC);

  p_mem_one_extra_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_MEM |=> fetch_o);

  p_alu_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && (op == OP_ADD || op == OP_SUBI)) |=> (fetch_o && pc_o == $past(pc_o) + AW'(4)));

  p_load_keeps_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MEM && op == OP_LD) |-> !mem_we);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(pc_o) && !mem_we));
endmodule

// File: tb/fetch_exec_seq_bench.sv
`timescale 1ns/1ps
module fetch_exec_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata, mem_wdata;
  logic        mem_we, fetch_o, done;
  logic [15:0] pc_o;

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:63];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  fetch_exec_seq u_fetch_exec_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .fetch_o(fetch_o), .pc_o(pc_o), .done(done));

  int errors = 0, checks = 0, cyc = 0, last_fetch = -1;
  logic [15:0] qf_addr[$];
  int          qf_gap[$];
  string       qf_tag[$];
  logic [15:0] qs_addr[$];
  logic [31:0] qs_data[$];
  string       qs_tag[$];

  function automatic logic [31:0] enc(input int op, rd, ra, rb, input logic [15:0] imm);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_fetch(input logic [15:0] a, input int gap, input string tag);
    qf_addr.push_back(a); qf_gap.push_back(gap); qf_tag.push_back(tag);
  endtask

  task automatic exp_store(input logic [15:0] a, input logic [31:0] d, input string tag);
    qs_addr.push_back(a); qs_data.push_back(d); qs_tag.push_back(tag);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (fetch_o) begin
      if (qf_addr.size() == 0) chk("R10 unexpected fetch", {16'd0, mem_addr}, 32'hFFFF_FFFF);
      else begin
        logic [15:0] a; int g; string t;
        a = qf_addr.pop_front(); g = qf_gap.pop_front(); t = qf_tag.pop_front();
        chk({t, " fetch addr"}, {16'd0, mem_addr}, {16'd0, a});
        if (g > 0) chk({t, " R3 gap"}, cyc - last_fetch, g);
      end
      last_fetch = cyc;
    end
    if (mem_we) begin
      if (qs_addr.size() == 0) chk("R5 unexpected store", {16'd0, mem_addr}, 32'hFFFF_FFFF);
      else begin
        logic [15:0] a; logic [31:0] d; string t;
        a = qs_addr.pop_front(); d = qs_data.pop_front(); t = qs_tag.pop_front();
        chk({t, " store addr"}, {16'd0, mem_addr}, {16'd0, a});
        chk({t, " store data"}, mem_wdata, d);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = enc(1, 1, 0, 0, 16'h80);
    mem[1]  = enc(1, 2, 0, 0, 16'h84);
    mem[2]  = enc(3, 3, 1, 2, 0);
    mem[3]  = enc(3, 3, 3, 1, 0);
    mem[4]  = enc(2, 0, 3, 0, 16'hA0);
    mem[5]  = enc(4, 4, 1, 0, 16'd5);
    mem[6]  = enc(5, 0, 4, 0, 16'd100);
    mem[7]  = enc(1, 5, 0, 0, 16'h88);
    mem[8]  = enc(5, 0, 5, 0, 16'd100);
    mem[9]  = enc(5, 0, 1, 0, 16'd44);
    mem[10] = enc(2, 0, 1, 0, 16'hB0);
    mem[11] = enc(6, 0, 1, 2, 16'd100);
    mem[12] = enc(6, 0, 2, 2, 16'd100);
    mem[13] = enc(6, 0, 2, 5, 16'd60);
    mem[14] = enc(2, 0, 5, 0, 16'hB4);
    mem[15] = enc(14, 1, 1, 1, 16'd0);
    mem[16] = enc(2, 0, 1, 0, 16'hA4);
    mem[17] = enc(2, 0, 2, 0, 16'hA8);
    mem[18] = enc(4, 2, 2, 0, 16'd3);
    mem[19] = enc(5, 0, 2, 0, 16'd72);
    mem[20] = enc(2, 0, 2, 0, 16'hAC);
    mem[21] = enc(7, 0, 0, 0, 16'd0);
    mem[32] = 32'd5; mem[33] = 32'd7; mem[34] = 32'hFFFF_FFFD;

    exp_fetch(0, 0, "R1");      exp_fetch(4, 3, "R4");     exp_fetch(8, 3, "R4");
    exp_fetch(12, 2, "R6");     exp_fetch(16, 2, "R6");    exp_fetch(20, 3, "R5");
    exp_fetch(24, 2, "R7");     exp_fetch(28, 2, "R8");    exp_fetch(32, 3, "R4");
    exp_fetch(36, 2, "R8");     exp_fetch(44, 2, "R8");    exp_fetch(48, 2, "R9");
    exp_fetch(52, 2, "R9");     exp_fetch(60, 2, "R9");    exp_fetch(64, 2, "R11");
    exp_fetch(68, 3, "R2");     exp_fetch(72, 3, "R2");    exp_fetch(76, 2, "R7");
    exp_fetch(72, 2, "R8");     exp_fetch(76, 2, "R7");    exp_fetch(72, 2, "R8");
    exp_fetch(76, 2, "R7");     exp_fetch(80, 2, "R8");    exp_fetch(84, 3, "R5");
    exp_store(16'hA0, 32'd17, "R6");
    exp_store(16'hA4, 32'd5, "R9");
    exp_store(16'hA8, 32'd7, "R9");
    exp_store(16'hAC, 32'hFFFF_FFFE, "R7");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch in reset", {31'd0, fetch_o}, 32'd1);
    chk("R1 pc in reset", {16'd0, pc_o}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 we in reset", {31'd0, mem_we}, 32'd0);
    rst_n = 1;

    begin
      int n;
      n = 0;
      while (!done && n < 2000) begin
        @(negedge clk);
        n++;
      end
      if (!done) begin
        errors++; checks++;
        $display("FAIL R10 watchdog actual=done=0 expected=done=1");
      end
    end

    repeat (10) @(negedge clk);
    chk("R10 done held", {31'd0, done}, 32'd1);
    chk("R10 pc holds halt address", {16'd0, pc_o}, 32'd84);
    chk("R2 fetch queue drained", qf_addr.size(), 0);
    chk("R5 store queue drained", qs_addr.size(), 0);
    chk("R4 load source unchanged", mem[32], 32'd5);
    chk("R4 negative source unchanged", mem[34], 32'hFFFF_FFFD);
    chk("R8 skipped store absent", mem[44], 32'd0);
    chk("R9 skipped store absent", mem[45], 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule